// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block sits behind the host register decode of a parallel port and turns host accesses at the two enhanced-mode offsets into byte transfers on a peripheral request/acknowledge handshake. The address offset carries one byte per access. The data offset carries one, two or four bytes per access, issued least significant byte first. A transfer starts only when the port control bits hold the exact pattern for its direction. Any other pattern turns the access into a no-op, and a read then returns all ones across the access width.

Each byte waits a bounded number of clocks for acknowledge. If acknowledge does not arrive in that time, a sticky timeout flag is set and the rest of the access is dropped. Software sees the flag as bit 0 of a status read, where it takes the place of bit 0 of the external status input. Software clears it by writing the status offset with bit 0 set. The host holds off new accesses while `host_ready` is low.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset, `host_ready` is 1, `per_req` is 0 and the timeout flag is clear.
- R2: A write at offset 3 or 4 starts a transfer only when `port_ctrl & 0x2F` equals 0x04. Bits 7, 6 and 4 of `port_ctrl` have no effect on this decision.
- R3: A read at offset 3 or 4 starts a transfer only when `port_ctrl & 0x2F` equals 0x24.
- R4: An access at offset 3 or 4 that fails its gate raises no `per_req` and keeps `host_ready` high. A read of this kind returns 0x000000FF for a byte, 0x0000FFFF for a half-word and 0xFFFFFFFF for a word.
- R5: Bytes of an offset 3 access drive `per_is_addr` = 1. Bytes of an offset 4 access drive `per_is_addr` = 0.
- R6: `host_size` encodes the access width: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. Offset 4 moves that many bytes, least significant first: write byte k comes from `host_wdata[8k+7:8k]`, and read byte k lands there. Offset 3 always moves one byte.
- R7: `host_ready` is low from the cycle after an accepted transfer until the last byte ends. With no timeout it is low for the sum of (ack wait + 1) over all bytes.
- R8: If `per_ack` does not arrive within TIMEOUT_CYCLES cycles of `per_req` for one byte, the timeout flag is set and the access ends. Bytes not yet moved are skipped, and on a read they read as 0xFF.
- R9: A status read (offset 1) returns `ext_status` in bits 7:1, the timeout flag in bit 0, and zeros in bits 31:8.
- R10: A status write with `host_wdata[0]` = 1 clears the timeout flag. A status write with bit 0 clear leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access strobe, taken when host_ready is high |
| host_we | input | 1 | 1 for write, 0 for read |
| host_off | input | 3 | Register offset within the port |
| host_size | input | 2 | Access width code |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read result, valid once host_ready is high again |
| host_ready | output | 1 | High when idle and able to take an access |
| port_ctrl | input | 8 | Current port control register value |
| ext_status | input | 8 | External status lines |
| per_req | output | 1 | Byte transfer request |
| per_is_addr | output | 1 | 1 for an address byte, 0 for a data byte |
| per_write | output | 1 | 1 when the byte goes to the peripheral |
| per_wdata | output | 8 | Byte sent to the peripheral |
| per_rdata | input | 8 | Byte returned by the peripheral, taken with per_ack |
| per_ack | input | 1 | One-cycle completion of the current byte |

## Verification
The assertions check on every cycle that requests happen only while the host is held off, that a pending byte does not change under the peripheral, that no request outlives the timeout window, that a gated access with a wrong pattern never requests, and that a status read reflects the flag. Only the bench's scenarios show the byte order of split accesses, the all-ones fill of blocked and partially completed reads, the exact length of the hold-off, and how the flag is set and then cleared by software.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam int unsigned HOST_BYTES = 4;
  localparam int unsigned HOST_W     = HOST_BYTES * 8;

  localparam logic [7:0] CTL_MASK  = 8'h2F;
  localparam logic [7:0] CTL_WRPAT = 8'h04;
  localparam logic [7:0] CTL_RDPAT = 8'h24;

  localparam logic [2:0] OFF_STATUS = 3'd1;
  localparam logic [2:0] OFF_ADDR   = 3'd3;
  localparam logic [2:0] OFF_DATA   = 3'd4;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_XFER = 1'b1} gate_state_e;

  function automatic logic gate_open(input logic [7:0] ctl, input logic is_read);
    return (ctl & CTL_MASK) == (is_read ? CTL_RDPAT : CTL_WRPAT);
  endfunction

  function automatic logic [2:0] byte_count(input logic [1:0] size, input logic is_addr);
    if (is_addr)          return 3'd1;
    else if (size == 2'd0) return 3'd1;
    else if (size == 2'd1) return 3'd2;
    else                   return 3'd4;
  endfunction

  function automatic logic [HOST_W-1:0] ones_fill(input logic [2:0] nbytes);
    logic [HOST_W-1:0] m;
    m = '0;
    for (int i = 0; i < HOST_BYTES; i++)
      if (i < int'(nbytes)) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction
endpackage

// File: rtl/epp_decode.sv
module epp_decode
  import epp_gate_pkg::*;
(
  input  logic [2:0] off,
  input  logic       we,
  input  logic [1:0] size,
  input  logic [7:0] ctl,
  output logic       is_epp,
  output logic       is_addr,
  output logic       is_status,
  output logic       open_ok,
  output logic [2:0] nbytes
);
  always_comb begin
    is_addr   = (off == OFF_ADDR);
    is_epp    = is_addr || (off == OFF_DATA);
    is_status = (off == OFF_STATUS);
    open_ok   = gate_open(ctl, !we);
    nbytes    = byte_count(size, is_addr);
  end
endmodule

// File: rtl/epp_timer.sv
module epp_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || restart)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_gate_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [2:0]  host_off,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_ready,
  input  logic [7:0]  port_ctrl,
  input  logic [7:0]  ext_status,
  output logic        per_req,
  output logic        per_is_addr,
  output logic        per_write,
  output logic [7:0]  per_wdata,
  input  logic [7:0]  per_rdata,
  input  logic        per_ack
);
  gate_state_e      state_q;
  logic [1:0]       idx_q, last_q;
  logic [HOST_W-1:0] wbuf_q, rdata_q;
  logic             is_addr_q, write_q, tmo_flag;

  logic       dec_epp, dec_addr, dec_status, dec_open;
  logic [2:0] dec_nbytes;
  logic       accept, start_xfer, byte_done, tmo_evt, expired, last_byte;

  epp_decode u_dec (
    .off(host_off), .we(host_we), .size(host_size), .ctl(port_ctrl),
    .is_epp(dec_epp), .is_addr(dec_addr), .is_status(dec_status),
    .open_ok(dec_open), .nbytes(dec_nbytes)
  );

  epp_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_XFER),
    .restart(per_ack), .expired(expired)
  );

  assign accept     = host_req && (state_q == ST_IDLE);
  assign start_xfer = accept && dec_epp && dec_open;
  assign byte_done  = (state_q == ST_XFER) && per_ack;
  assign tmo_evt    = (state_q == ST_XFER) && !per_ack && expired;
  assign last_byte  = (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      last_q    <= '0;
      wbuf_q    <= '0;
      rdata_q   <= '0;
      is_addr_q <= 1'b0;
      write_q   <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (accept) begin
        if (dec_status) begin
          if (!host_we) rdata_q <= {24'h0, ext_status[7:1], tmo_flag};
        end else if (dec_epp) begin
          if (!host_we) rdata_q <= ones_fill(dec_nbytes);
          if (start_xfer) begin
            state_q   <= ST_XFER;
            idx_q     <= '0;
            last_q    <= 2'(dec_nbytes - 3'd1);
            wbuf_q    <= host_wdata;
            is_addr_q <= dec_addr;
            write_q   <= host_we;
          end
        end else if (!host_we) begin
          rdata_q <= 32'h0000_00FF;
        end
      end
    end else begin
      if (byte_done) begin
        if (!write_q) rdata_q[{idx_q, 3'b000} +: 8] <= per_rdata;
        if (last_byte) state_q <= ST_IDLE;
        else           idx_q   <= idx_q + 1'b1;
      end else if (tmo_evt) begin
        state_q <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                            tmo_flag <= 1'b0;
    else if (tmo_evt)                                      tmo_flag <= 1'b1;
    else if (accept && dec_status && host_we && host_wdata[0]) tmo_flag <= 1'b0;
  end

  assign host_ready  = (state_q == ST_IDLE);
  assign host_rdata  = rdata_q;
  assign per_req     = (state_q == ST_XFER);
  assign per_is_addr = is_addr_q;
  assign per_write   = write_q;
  assign per_wdata   = wbuf_q[{idx_q, 3'b000} +: 8];
endmodule

// File: rtl/epp_cycle_gate_chk.sv
module epp_cycle_gate_chk #(
  parameter int unsigned LIMIT = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_req,
  input logic        host_ready,
  input logic        host_we,
  input logic [2:0]  host_off,
  input logic [7:0]  port_ctrl,
  input logic [31:0] host_rdata,
  input logic        per_req,
  input logic        per_ack,
  input logic [7:0]  per_wdata,
  input logic        tmo_flag,
  input logic        tmo_evt
);
  localparam int unsigned SW = $clog2(LIMIT + 2);
  logic [SW-1:0] stall_q;
  logic          epp_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  stall_q <= '0;
    else if (per_req && !per_ack) stall_q <= stall_q + 1'b1;
    else                          stall_q <= '0;
  end

  assign epp_acc = host_req && host_ready && (host_off == 3'd3 || host_off == 3'd4);

  AST_REQ_HOLDS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> !host_ready); // R7
  AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req && !per_ack) |=> (!per_req || $stable(per_wdata))); // R6
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (epp_acc && host_we && ((port_ctrl & 8'h2F) != 8'h04)) |=> !per_req); // R2
  AST_WR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (epp_acc && host_we && ((port_ctrl & 8'h2F) == 8'h04)) |=> per_req); // R2
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (epp_acc && !host_we && ((port_ctrl & 8'h2F) != 8'h24)) |=> !per_req); // R3
  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> (int'(stall_q) < LIMIT)); // R8
  AST_TMO_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (tmo_flag && !per_req)); // R8
  AST_STATUS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_ready && !host_we && host_off == 3'd1) |=> (host_rdata[0] == $past(tmo_flag))); // R9
endmodule

bind epp_cycle_gate epp_cycle_gate_chk #(.LIMIT(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ready(host_ready),
  .host_we(host_we), .host_off(host_off), .port_ctrl(port_ctrl),
  .host_rdata(host_rdata), .per_req(per_req), .per_ack(per_ack),
  .per_wdata(per_wdata), .tmo_flag(tmo_flag), .tmo_evt(tmo_evt)
);

// File: tb/epp_cycle_gate_bench.sv
module epp_cycle_gate_bench;
  localparam int LIMIT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [2:0]  host_off = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ready;
  logic [7:0]  port_ctrl = 8'hCC;
  logic [7:0]  ext_status = 8'hFF;
  logic        per_req, per_is_addr, per_write;
  logic [7:0]  per_wdata;
  logic [7:0]  per_rdata = 8'h00;
  logic        per_ack = 1'b0;

  int checks = 0, errors = 0;
  int ack_delay = 0, ack_left = 1000, wait_cnt = 0, nlog = 0;
  logic [7:0] log_data [0:31];
  logic       log_addr [0:31];
  logic       log_wr   [0:31];

  always #2.5 clk = ~clk;

  epp_cycle_gate #(.TIMEOUT_CYCLES(LIMIT)) u_epp_cycle_gate (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ready(host_ready), .port_ctrl(port_ctrl),
    .ext_status(ext_status), .per_req(per_req), .per_is_addr(per_is_addr),
    .per_write(per_write), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .per_ack(per_ack)
  );

  // peripheral model: acks after ack_delay waiting cycles while budget remains
  always @(negedge clk) begin
    per_ack = 1'b0;
    if (rst_n && per_req) begin
      if (ack_left > 0 && wait_cnt == ack_delay) begin
        per_ack   = 1'b1;
        per_rdata = 8'hA0 + 8'(nlog);
        log_data[nlog] = per_wdata;
        log_addr[nlog] = per_is_addr;
        log_wr[nlog]   = per_write;
        nlog++;
        ack_left--;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end else begin
      wait_cnt = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [2:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, output int busy);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_off = off; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    busy = 0;
    while (!host_ready) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int b;
    chk("R1 ready", 32'(host_ready), 32'd1);
    chk("R1 per_req", 32'(per_req), 32'd0);
    ext_status = 8'hFF;
    access(1'b0, 3'd1, 2'd0, 32'h0, b);
    chk("R1 R9 status flag clear", host_rdata, 32'h0000_00FE);
  endtask

  task automatic t_addr_write();
    int b, n0;
    n0 = nlog; port_ctrl = 8'h04; ack_delay = 0;
    access(1'b1, 3'd3, 2'd2, 32'hFFFF_FF5A, b);
    chk("R5 R6 one addr byte", 32'(nlog - n0), 32'd1);
    chk("R5 addr flag", 32'(log_addr[n0]), 32'd1);
    chk("R2 write dir", 32'(log_wr[n0]), 32'd1);
    chk("R6 addr byte value", 32'(log_data[n0]), 32'h5A);
    chk("R7 busy 1 byte", 32'(b), 32'd1);
  endtask

  task automatic t_word_write();
    int b, n0;
    n0 = nlog; port_ctrl = 8'hD4; ack_delay = 0;
    access(1'b1, 3'd4, 2'd2, 32'h4433_2211, b);
    chk("R2 ignored bits, 4 bytes", 32'(nlog - n0), 32'd4);
    chk("R6 byte0", 32'(log_data[n0]),   32'h11);
    chk("R6 byte1", 32'(log_data[n0+1]), 32'h22);
    chk("R6 byte2", 32'(log_data[n0+2]), 32'h33);
    chk("R6 byte3", 32'(log_data[n0+3]), 32'h44);
    chk("R5 data flag", 32'(log_addr[n0]), 32'd0);
    chk("R7 busy 4 bytes", 32'(b), 32'd4);
  endtask

  task automatic t_blocked_write();
    int b, n0;
    n0 = nlog;
    port_ctrl = 8'h05;
    access(1'b1, 3'd4, 2'd0, 32'h77, b);
    chk("R2 R4 strobe blocks write", 32'(nlog - n0), 32'd0);
    chk("R4 ready stays high", 32'(b), 32'd0);
    port_ctrl = 8'h24;
    access(1'b1, 3'd3, 2'd0, 32'h77, b);
    chk("R2 direction blocks write", 32'(nlog - n0), 32'd0);
  endtask

  task automatic t_half_read();
    int b, n0;
    n0 = nlog; port_ctrl = 8'h24; ack_delay = 0;
    access(1'b0, 3'd4, 2'd1, 32'h0, b);
    chk("R3 R6 half read LE", host_rdata,
        {16'h0, 8'hA0 + 8'(n0 + 1), 8'hA0 + 8'(n0)});
    chk("R7 busy 2 bytes", 32'(b), 32'd2);
    ack_delay = 2;
    access(1'b0, 3'd4, 2'd1, 32'h0, b);
    chk("R7 busy with ack wait", 32'(b), 32'd6);
    ack_delay = 0;
  endtask

  task automatic t_blocked_read();
    int b, n0;
    n0 = nlog;
    port_ctrl = 8'h04;
    access(1'b0, 3'd4, 2'd2, 32'h0, b);
    chk("R3 R4 word fill", host_rdata, 32'hFFFF_FFFF);
    access(1'b0, 3'd4, 2'd1, 32'h0, b);
    chk("R4 half fill", host_rdata, 32'h0000_FFFF);
    port_ctrl = 8'h20;
    access(1'b0, 3'd3, 2'd0, 32'h0, b);
    chk("R4 byte fill", host_rdata, 32'h0000_00FF);
    chk("R3 R4 no transfers", 32'(nlog - n0), 32'd0);
  endtask

  task automatic t_addr_read();
    int b, n0;
    n0 = nlog; port_ctrl = 8'hE4;
    access(1'b0, 3'd3, 2'd2, 32'h0, b);
    chk("R5 R6 addr read single byte", host_rdata, {24'h0, 8'hA0 + 8'(n0)});
    chk("R5 addr read flag", 32'(log_addr[n0]), 32'd1);
  endtask

  task automatic t_timeout();
    int b;
    port_ctrl = 8'h04; ack_left = 0;
    access(1'b1, 3'd4, 2'd0, 32'h99, b);
    chk("R8 gives up after limit", 32'(b), 32'(LIMIT));
    ext_status = 8'h00;
    access(1'b0, 3'd1, 2'd0, 32'h0, b);
    chk("R8 R9 flag in bit0", host_rdata, 32'h0000_0001);
    access(1'b1, 3'd1, 2'd0, 32'hFE, b);
    access(1'b0, 3'd1, 2'd0, 32'h0, b);
    chk("R10 bit0 clear keeps flag", host_rdata, 32'h0000_0001);
    access(1'b1, 3'd1, 2'd0, 32'h01, b);
    ext_status = 8'h81;
    access(1'b0, 3'd1, 2'd0, 32'h0, b);
    chk("R10 R9 flag cleared, ext bit0 hidden", host_rdata, 32'h0000_0080);
    ack_left = 1000;
  endtask

  task automatic t_partial();
    int b, n0;
    n0 = nlog; port_ctrl = 8'h24; ack_left = 2;
    access(1'b0, 3'd4, 2'd2, 32'h0, b);
    chk("R8 partial read fill", host_rdata,
        {16'hFFFF, 8'hA0 + 8'(n0 + 1), 8'hA0 + 8'(n0)});
    chk("R8 stop after first timeout", 32'(b), 32'(2 + LIMIT));
    chk("R8 bytes moved", 32'(nlog - n0), 32'd2);
    ext_status = 8'h00;
    access(1'b0, 3'd1, 2'd0, 32'h0, b);
    chk("R8 flag set by partial", host_rdata, 32'h0000_0001);
    ack_left = 1000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_write();
    t_word_write();
    t_blocked_write();
    t_half_read();
    t_blocked_read();
    t_addr_read();
    t_timeout();
    t_partial();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule